// File: doc/BRIEF.md
# Masked Broadcast Activity Controller

This block is the slave-side gate that decides whether one node of a processing grid takes part in a parallel step. A master drives two kinds of transfer to every node at once. A mask transfer carries a 32-bit map and a 3-bit set-operation code. Each node picks its own bit from the map and combines it with its stored one-bit activity flag. A broadcast transfer carries a 32-bit control word and a 3-bit target code. The node passes the word to its local decoder only when its activity state matches the target code. A one-cycle valid strobe marks each word that is passed on.

The node's grid coordinates are parameters. The bit a node reads from the map is fixed when the block is built, from its position in a square grid. With set operations, the master can shape active regions over a few cycles, for example by splitting the grid into a checkerboard and then inverting it. Broadcasts can address the active nodes, the inactive nodes, or every node.

Top module: `node_activity_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `active_o` is 0, `fwd_vld_o` is 0 and `fwd_word_o` is 0.
- R2: The node's map bit is at index (NODE_X*GRID_DIM + NODE_Y) mod MAP_W. A mask transfer with code 3'b000 loads that bit into the flag, and `active_o` shows the new flag after the next rising clock edge.
- R3: A mask transfer with code 3'b001 sets the flag to the AND of the map bit and the previous flag.
- R4: A mask transfer with code 3'b010 sets the flag to the OR of the map bit and the previous flag. Code 3'b011 sets it to their XOR.
- R5: A mask transfer with any code whose top bit is 1 (3'b100 to 3'b111, including the reserved 3'b110) leaves the flag unchanged.
- R6: A broadcast with code 3'b100 is forwarded only when the flag is 1.
- R7: A broadcast with code 3'b101 is forwarded only when the flag is 0.
- R8: A broadcast with code 3'b111 is forwarded whatever the flag holds.
- R9: A broadcast with any other code (3'b000 to 3'b011, or the reserved 3'b110) is not forwarded. No broadcast ever changes the flag.
- R10: When a broadcast is forwarded, `fwd_vld_o` is 1 for exactly the one cycle after the broadcast, and `fwd_word_o` then holds the word. `fwd_word_o` keeps the last forwarded word until the next forward.
- R11: If a mask transfer and a broadcast arrive in the same cycle, the mask is applied and the broadcast is dropped.
- R12: Map bits other than the node's own bit have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mask_vld | input | 1 | A mask transfer is present this cycle |
| mask_map | input | 32 | Mask map, one bit per node index |
| mask_code | input | 3 | Set-operation code for the mask |
| bcast_vld | input | 1 | A broadcast transfer is present this cycle |
| bcast_word | input | 32 | Control word to forward |
| bcast_code | input | 3 | Broadcast target code |
| active_o | output | 1 | Current activity flag |
| fwd_vld_o | output | 1 | One-cycle strobe: `fwd_word_o` carries a newly forwarded word |
| fwd_word_o | output | 32 | Last forwarded control word |

## Verification
The bench builds the node at coordinates (3,5) with a 16-wide grid and a 32-bit map. The node's index, 53, then wraps to bit 21, so the modulo step of the index mapping is exercised. The bench sweeps all eight mask codes against both earlier flag values and both map-bit values. In every case the other 31 map bits are driven to the opposite value, so a wrongly picked bit shows up at once. All eight broadcast codes are swept against both flag states, with a check of the strobe width and of word holding, and a collision cycle is also driven.

// File: rtl/nac_pkg.sv
package nac_pkg;
  localparam int unsigned CODE_W = 3;

  localparam logic [CODE_W-1:0] MC_LOAD = 3'b000;
  localparam logic [CODE_W-1:0] MC_AND  = 3'b001;
  localparam logic [CODE_W-1:0] MC_OR   = 3'b010;
  localparam logic [CODE_W-1:0] MC_XOR  = 3'b011;

  localparam logic [CODE_W-1:0] BC_ACTIVE   = 3'b100;
  localparam logic [CODE_W-1:0] BC_INACTIVE = 3'b101;
  localparam logic [CODE_W-1:0] BC_ALL      = 3'b111;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_AND,
    OP_OR,
    OP_XOR
  } mask_op_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_ACTIVE,
    TGT_INACTIVE,
    TGT_ALL
  } bcast_tgt_e;

  function automatic int unsigned node_bit_index(int unsigned x, int unsigned y,
                                                 int unsigned dim, int unsigned width);
    return (x * dim + y) % width;
  endfunction

  function automatic mask_op_e decode_mask(logic [CODE_W-1:0] code);
    case (code)
      MC_LOAD: return OP_LOAD;
      MC_AND:  return OP_AND;
      MC_OR:   return OP_OR;
      MC_XOR:  return OP_XOR;
      default: return OP_HOLD;
    endcase
  endfunction

  function automatic bcast_tgt_e decode_bcast(logic [CODE_W-1:0] code);
    case (code)
      BC_ACTIVE:   return TGT_ACTIVE;
      BC_INACTIVE: return TGT_INACTIVE;
      BC_ALL:      return TGT_ALL;
      default:     return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/nac_rst_sync.sv
module nac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/nac_mask_pick.sv
module nac_mask_pick #(
  parameter int unsigned MAP_W    = 32,
  parameter int unsigned NODE_X   = 0,
  parameter int unsigned NODE_Y   = 0,
  parameter int unsigned GRID_DIM = 16
) (
  input  logic [MAP_W-1:0] map_i,
  output logic             bit_o
);
  import nac_pkg::*;
  localparam int unsigned IDX = node_bit_index(NODE_X, NODE_Y, GRID_DIM, MAP_W);

  generate
    if (MAP_W == 1) begin : g_single
      assign bit_o = map_i[0];
    end else begin : g_multi
      assign bit_o = map_i[IDX];
    end
  endgenerate
endmodule

// File: rtl/nac_flag_unit.sv
module nac_flag_unit (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_en,
  input  logic [nac_pkg::CODE_W-1:0] code_i,
  input  logic                   mask_bit,
  output logic                   flag_o
);
  import nac_pkg::*;

  mask_op_e op;
  logic     flag_q;
  logic     flag_d;
  logic     flag_en;

  always_comb begin
    op      = decode_mask(code_i);
    flag_en = upd_en && (op != OP_HOLD);
    case (op)
      OP_LOAD: flag_d = mask_bit;
      OP_AND:  flag_d = mask_bit & flag_q;
      OP_OR:   flag_d = mask_bit | flag_q;
      OP_XOR:  flag_d = mask_bit ^ flag_q;
      default: flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/nac_bcast_filter.sv
module nac_bcast_filter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bcast_vld,
  input  logic                   mask_busy,
  input  logic [nac_pkg::CODE_W-1:0] code_i,
  input  logic [WORD_W-1:0]      word_i,
  input  logic                   flag_i,
  output logic                   fwd_vld_o,
  output logic [WORD_W-1:0]      fwd_word_o
);
  import nac_pkg::*;

  bcast_tgt_e  tgt;
  logic        match;
  logic        take;
  logic        vld_q;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    tgt = decode_bcast(code_i);
    case (tgt)
      TGT_ACTIVE:   match = flag_i;
      TGT_INACTIVE: match = !flag_i;
      TGT_ALL:      match = 1'b1;
      default:      match = 1'b0;
    endcase
    take = bcast_vld && !mask_busy && match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (take) begin
      word_q <= word_i;
    end
  end

  assign fwd_vld_o  = vld_q;
  assign fwd_word_o = word_q;
endmodule

// File: rtl/node_activity_ctrl.sv
module node_activity_ctrl #(
  parameter int unsigned NODE_X   = 0,
  parameter int unsigned NODE_Y   = 0,
  parameter int unsigned GRID_DIM = 16,
  parameter int unsigned MAP_W    = 32,
  parameter int unsigned WORD_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mask_vld,
  input  logic [MAP_W-1:0]            mask_map,
  input  logic [nac_pkg::CODE_W-1:0]  mask_code,
  input  logic                        bcast_vld,
  input  logic [WORD_W-1:0]           bcast_word,
  input  logic [nac_pkg::CODE_W-1:0]  bcast_code,
  output logic                        active_o,
  output logic                        fwd_vld_o,
  output logic [WORD_W-1:0]           fwd_word_o
);
  logic rst_sync_n;
  logic own_bit;
  logic flag;

  nac_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  nac_mask_pick #(
    .MAP_W    (MAP_W),
    .NODE_X   (NODE_X),
    .NODE_Y   (NODE_Y),
    .GRID_DIM (GRID_DIM)
  ) u_pick (
    .map_i (mask_map),
    .bit_o (own_bit)
  );

  nac_flag_unit u_flag (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_en   (mask_vld),
    .code_i   (mask_code),
    .mask_bit (own_bit),
    .flag_o   (flag)
  );

  nac_bcast_filter #(.WORD_W(WORD_W)) u_filt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bcast_vld  (bcast_vld),
    .mask_busy  (mask_vld),
    .code_i     (bcast_code),
    .word_i     (bcast_word),
    .flag_i     (flag),
    .fwd_vld_o  (fwd_vld_o),
    .fwd_word_o (fwd_word_o)
  );

  assign active_o = flag;
endmodule

// File: rtl/nac_checker.sv
module nac_checker #(
  parameter int unsigned NODE_X   = 0,
  parameter int unsigned NODE_Y   = 0,
  parameter int unsigned GRID_DIM = 16,
  parameter int unsigned MAP_W    = 32,
  parameter int unsigned WORD_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mask_vld,
  input logic [MAP_W-1:0]  mask_map,
  input logic [2:0]        mask_code,
  input logic              bcast_vld,
  input logic [2:0]        bcast_code,
  input logic              active_o,
  input logic              fwd_vld_o,
  input logic [WORD_W-1:0] fwd_word_o
);
  localparam int unsigned IDX = nac_pkg::node_bit_index(NODE_X, NODE_Y, GRID_DIM, MAP_W);

  AST_LOAD_OWN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vld && mask_code == 3'b000) |=> (active_o == $past(mask_map[IDX]))); // R2

  AST_UPPER_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vld && mask_code[2]) |=> $stable(active_o)); // R5

  AST_BCAST_NO_FLAG_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_vld |=> $stable(active_o)); // R9

  AST_ACTIVE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_vld && !mask_vld && bcast_code == 3'b100 && !active_o) |=> !fwd_vld_o); // R6

  AST_INACTIVE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_vld && !mask_vld && bcast_code == 3'b101 && active_o) |=> !fwd_vld_o); // R7

  AST_ALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_vld && !mask_vld && bcast_code == 3'b111) |=> fwd_vld_o); // R8

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld_o |-> $past(bcast_vld)); // R10

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_vld_o |-> $stable(fwd_word_o)); // R10

  AST_MASK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vld && bcast_vld) |=> !fwd_vld_o); // R11
endmodule

bind node_activity_ctrl nac_checker #(
  .NODE_X   (NODE_X),
  .NODE_Y   (NODE_Y),
  .GRID_DIM (GRID_DIM),
  .MAP_W    (MAP_W),
  .WORD_W   (WORD_W)
) u_nac_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mask_vld   (mask_vld),
  .mask_map   (mask_map),
  .mask_code  (mask_code),
  .bcast_vld  (bcast_vld),
  .bcast_code (bcast_code),
  .active_o   (active_o),
  .fwd_vld_o  (fwd_vld_o),
  .fwd_word_o (fwd_word_o)
);

// File: tb/node_activity_ctrl_tb.sv
module node_activity_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NX = 3;
  localparam int NY = 5;
  localparam int DIM = 16;
  localparam int MW = 32;
  localparam int WW = 32;
  localparam int OWN = (NX * DIM + NY) % MW;

  logic          clk;
  logic          rst_n;
  logic          mask_vld;
  logic [MW-1:0] mask_map;
  logic [2:0]    mask_code;
  logic          bcast_vld;
  logic [WW-1:0] bcast_word;
  logic [2:0]    bcast_code;
  logic          active_o;
  logic          fwd_vld_o;
  logic [WW-1:0] fwd_word_o;

  int n_tests;
  int n_fail;
  logic [WW-1:0] exp_word;

  node_activity_ctrl #(
    .NODE_X(NX), .NODE_Y(NY), .GRID_DIM(DIM), .MAP_W(MW), .WORD_W(WW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mask_vld(mask_vld), .mask_map(mask_map), .mask_code(mask_code),
    .bcast_vld(bcast_vld), .bcast_word(bcast_word), .bcast_code(bcast_code),
    .active_o(active_o), .fwd_vld_o(fwd_vld_o), .fwd_word_o(fwd_word_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic mv, input logic [2:0] mc, input logic [MW-1:0] mm,
                      input logic bv, input logic [2:0] bc, input logic [WW-1:0] bw);
    @(negedge clk);
    mask_vld = mv; mask_code = mc; mask_map = mm;
    bcast_vld = bv; bcast_code = bc; bcast_word = bw;
    @(posedge clk);
    @(negedge clk);
    mask_vld = 1'b0; bcast_vld = 1'b0;
  endtask

  function automatic logic [MW-1:0] map_for(input logic b);
    logic [MW-1:0] one;
    one = '0;
    one[OWN] = 1'b1;
    return b ? one : ~one;
  endfunction

  task automatic set_flag(input logic v);
    step(1'b1, 3'b000, map_for(v), 1'b0, 3'b000, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0;
    mask_vld = 1'b0; mask_code = '0; mask_map = '0;
    bcast_vld = 1'b0; bcast_code = '0; bcast_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 active in reset", {31'b0, active_o}, 32'd0);
    check("R1 strobe in reset", {31'b0, fwd_vld_o}, 32'd0);
    check("R1 word in reset", fwd_word_o, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 active after reset", {31'b0, active_o}, 32'd0);
    check("R1 word after reset", fwd_word_o, 32'd0);
    exp_word = '0;

    // Mask sweep: R2 R3 R4 R5 R12
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int m = 0; m < 2; m++) begin
          logic e;
          string tag;
          set_flag(p[0]);
          step(1'b1, c[2:0], map_for(m[0]), 1'b0, 3'b000, '0);
          case (c)
            0: begin e = m[0];          tag = "R2 R12 load"; end
            1: begin e = m[0] & p[0];   tag = "R3 and"; end
            2: begin e = m[0] | p[0];   tag = "R4 or"; end
            3: begin e = m[0] ^ p[0];   tag = "R4 xor"; end
            default: begin e = p[0];    tag = "R5 hold"; end
          endcase
          check(tag, {31'b0, active_o}, {31'b0, e});
        end
      end
    end

    // Broadcast sweep: R6 R7 R8 R9 R10
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 8; c++) begin
        logic go;
        logic [WW-1:0] w;
        string tag;
        w = 32'hC0DE_0000 + 32'(c * 16 + f + 1);
        set_flag(f[0]);
        step(1'b0, 3'b000, '0, 1'b1, c[2:0], w);
        case (c)
          4: begin go = f[0];  tag = "R6 active target"; end
          5: begin go = !f[0]; tag = "R7 inactive target"; end
          7: begin go = 1'b1;  tag = "R8 all target"; end
          default: begin go = 1'b0; tag = "R9 no target"; end
        endcase
        if (go) exp_word = w;
        check(tag, {31'b0, fwd_vld_o}, {31'b0, go});
        check("R10 word", fwd_word_o, exp_word);
        check("R9 flag unchanged", {31'b0, active_o}, {31'b0, f[0]});
        @(negedge clk);
        check("R10 one cycle strobe", {31'b0, fwd_vld_o}, 32'd0);
        check("R10 word held", fwd_word_o, exp_word);
      end
    end

    // Collision: R11
    set_flag(1'b0);
    step(1'b1, 3'b000, map_for(1'b1), 1'b1, 3'b111, 32'hDEAD_BEEF);
    check("R11 mask applied", {31'b0, active_o}, 32'd1);
    check("R11 broadcast dropped", {31'b0, fwd_vld_o}, 32'd0);
    check("R11 word unchanged", fwd_word_o, exp_word);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule